// File: doc/BRIEF.md
# Sized Logical Read-Modify-Write Unit

This block executes the three bitwise logic functions (AND, OR, exclusive-OR) for a processor pipeline. A decoded 8-bit opcode picks both the function and the destination form. The destination is either a register, in which case the result is handed back for the register file, or a memory operand whose address is the destination register value. Memory forms work on a 32-bit word, a 16-bit half-word or an 8-bit byte.

A request is presented for one cycle on `issue_i`, together with the opcode, the source value, the destination value and the current flags. For a register form the result, the register write strobe and the updated flags appear in the next cycle. For a memory form the unit reads the addressed 32-bit word, combines the selected lane with the low bits of the source, and writes the result back to the same word with byte enables that cover only that lane. Each access waits as long as the memory holds `mem_ready_i` low. A one-cycle `done_o` pulse ends every legal operation, and opcodes outside the set raise `illegal_o` and change nothing.

The memory port is word-addressed: `mem_addr_o` carries the destination address with its two low bits cleared, and lanes are little-endian, so byte k of a word is data bits [8k+7:8k]. The bit that selects the byte inside a half-word is ignored, so half-words are always aligned.

Top module: `logic_rmw_unit`

## Requirements
- R1: Opcode decode. High nibble 8 with low nibble 2, 4, 5 or 6 selects AND. High nibble 9 with low nibble 2, 4, 5 or 6 selects OR, and with low nibble A, C, D or E it selects exclusive-OR. Low nibble 2 or A is the register form, 4 or C the memory word, 5 or D the memory half-word, and 6 or E the memory byte.
- R2: A register form raises `done_o`, `reg_we_o` and `flags_we_o` in the cycle after the issue cycle, with `reg_wdata_o` equal to the 32-bit function of `src_i` and `dst_i`. It makes no memory access.
- R3: A memory form first reads (`mem_we_o`=0) at `mem_addr_o` = `dst_i` with bits [1:0] cleared, then writes (`mem_we_o`=1) to the same address. `reg_we_o` stays low.
- R4: Word forms use all 32 bits. Half-word forms combine `src_i[15:0]` with the lane selected by address bit 1 and write with enables 4'b0011 or 4'b1100. Byte forms combine `src_i[7:0]` with byte lane address bits [1:0] and write with enable 4'b0001 shifted left by that lane. Every lane outside the enables is left unchanged.
- R5: `flags_o` is {N,Z,V,C} in bits 3..0 and is valid while `flags_we_o` is high, which happens exactly with `done_o`. N is bit 31, 15 or 7 of the result for word/register, half-word or byte size. Z is set when all bits of that size are zero. V and C equal `flags_i[1:0]` as sampled in the issue cycle.
- R6: While `mem_ready_i` is low, the request is held with stable address, direction, data and enables. With w wait states per access, `done_o` appears 3+2w cycles after the issue cycle.
- R7: An opcode outside the R1 set raises `illegal_o` for one cycle after the issue cycle. It raises no `done_o`, `reg_we_o`, `flags_we_o` or memory request, and it leaves memory unchanged.
- R8: `issue_i` is ignored while `busy_o` is high. After `done_o` or `illegal_o` the unit returns to idle with `busy_o` low and no further pulse.
- R9: After reset `busy_o`, `done_o`, `illegal_o`, `reg_we_o`, `flags_we_o` and `mem_req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Start request, sampled only when idle |
| opcode_i | input | 8 | Decoded operation code |
| src_i | input | 32 | Source register value |
| dst_i | input | 32 | Destination register value or memory pointer |
| flags_i | input | 4 | Current {N,Z,V,C} |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle unknown-opcode pulse |
| reg_we_o | output | 1 | Destination register write strobe |
| reg_wdata_o | output | 32 | Destination register result |
| flags_we_o | output | 1 | Flag update strobe |
| flags_o | output | 4 | Updated {N,Z,V,C} |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word-aligned address |
| mem_be_o | output | 4 | Byte enables for the write |
| mem_wdata_o | output | 32 | Write data, lane replicated |
| mem_rdata_i | input | 32 | Read data |
| mem_ready_i | input | 1 | Access accepted this cycle |

## Verification
A wrong stored function, size or lane would corrupt exactly one lane of the destination word, or leave a neighbouring lane modified. This shows in the memory model at the write-back, two cycles plus the wait states after issue, and in N and Z on the same `done_o` pulse. A corrupted state sequence shows as a latency that differs from 1 or 3+2w cycles, a missing write after the read, or a second pulse after completion. The sweeps cover every opcode value, every lane and several wait-state counts, so these errors surface within one operation.

// File: rtl/lrmw_pkg.sv
package lrmw_pkg;
    typedef enum logic [1:0] {FN_AND, FN_OR, FN_XOR} fn_e;
    typedef enum logic [1:0] {SZ_REG, SZ_WORD, SZ_HALF, SZ_BYTE} sz_e;
    typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_WRITE, ST_FIN, ST_ILL} st_e;
    localparam int DW = 32;
    localparam int BW = DW / 8;
endpackage

// File: rtl/lrmw_decode.sv
module lrmw_decode
    import lrmw_pkg::*;
(
    input  logic [7:0] opcode_i,
    output logic       legal_o,
    output fn_e        fn_o,
    output sz_e        sz_o
);
    logic form_ok;

    always_comb begin
        form_ok = 1'b1;
        sz_o    = SZ_REG;
        case (opcode_i[2:0])
            3'd2:    sz_o = SZ_REG;
            3'd4:    sz_o = SZ_WORD;
            3'd5:    sz_o = SZ_HALF;
            3'd6:    sz_o = SZ_BYTE;
            default: form_ok = 1'b0;
        endcase

        fn_o    = FN_AND;
        legal_o = 1'b0;
        case (opcode_i[7:4])
            4'h8: begin
                fn_o    = FN_AND;
                legal_o = form_ok && !opcode_i[3];
            end
            4'h9: begin
                fn_o    = opcode_i[3] ? FN_XOR : FN_OR;
                legal_o = form_ok;
            end
            default: legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lrmw_alu.sv
module lrmw_alu
    import lrmw_pkg::*;
(
    input  fn_e           fn_i,
    input  sz_e           sz_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [1:0]    lane_i,
    output logic [DW-1:0] res_o,
    output logic          n_o,
    output logic          z_o,
    output logic [DW-1:0] wdata_o,
    output logic [BW-1:0] be_o
);
    logic [DW-1:0] mask;
    logic [DW-1:0] b_sh;
    logic [DW-1:0] opa;
    logic [DW-1:0] opb;

    always_comb begin
        case (sz_i)
            SZ_BYTE: begin
                mask = 32'h0000_00FF;
                b_sh = b_i >> {lane_i, 3'b000};
            end
            SZ_HALF: begin
                mask = 32'h0000_FFFF;
                b_sh = b_i >> {lane_i[1], 4'b0000};
            end
            default: begin
                mask = '1;
                b_sh = b_i;
            end
        endcase

        opa = a_i & mask;
        opb = b_sh & mask;

        case (fn_i)
            FN_AND:  res_o = opa & opb;
            FN_OR:   res_o = opa | opb;
            default: res_o = opa ^ opb;
        endcase

        z_o = (res_o == '0);

        case (sz_i)
            SZ_BYTE: begin
                n_o     = res_o[7];
                wdata_o = {4{res_o[7:0]}};
                be_o    = 4'b0001 << lane_i;
            end
            SZ_HALF: begin
                n_o     = res_o[15];
                wdata_o = {2{res_o[15:0]}};
                be_o    = lane_i[1] ? 4'b1100 : 4'b0011;
            end
            default: begin
                n_o     = res_o[DW-1];
                wdata_o = res_o;
                be_o    = '1;
            end
        endcase
    end
endmodule

// File: rtl/logic_rmw_unit.sv
module logic_rmw_unit
    import lrmw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [7:0]    opcode_i,
    input  logic [31:0]   src_i,
    input  logic [31:0]   dst_i,
    input  logic [3:0]    flags_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          illegal_o,
    output logic          reg_we_o,
    output logic [31:0]   reg_wdata_o,
    output logic          flags_we_o,
    output logic [3:0]    flags_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [3:0]    mem_be_o,
    output logic [31:0]   mem_wdata_o,
    input  logic [31:0]   mem_rdata_i,
    input  logic          mem_ready_i
);
    typedef struct packed {
        st_e           st;
        fn_e           fn;
        sz_e           sz;
        logic [DW-1:0] src;
        logic [AW-1:0] addr;
        logic [DW-1:0] res;
        logic [DW-1:0] wdata;
        logic [BW-1:0] be;
        logic          n;
        logic          z;
        logic          v;
        logic          c;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic          dec_legal;
    fn_e           dec_fn;
    sz_e           dec_sz;
    fn_e           alu_fn;
    sz_e           alu_sz;
    logic [DW-1:0] alu_a;
    logic [DW-1:0] alu_b;
    logic [1:0]    alu_lane;
    logic [DW-1:0] alu_res;
    logic [DW-1:0] alu_wdata;
    logic [BW-1:0] alu_be;
    logic          alu_n;
    logic          alu_z;

    lrmw_decode u_decode (
        .opcode_i (opcode_i),
        .legal_o  (dec_legal),
        .fn_o     (dec_fn),
        .sz_o     (dec_sz)
    );

    // When idle the ALU sees the incoming operands (register form);
    // afterwards it sees the stored context and the read data.
    always_comb begin
        if (ctx_q.st == ST_IDLE) begin
            alu_fn   = dec_fn;
            alu_sz   = dec_sz;
            alu_a    = src_i;
            alu_b    = dst_i;
            alu_lane = dst_i[1:0];
        end else begin
            alu_fn   = ctx_q.fn;
            alu_sz   = ctx_q.sz;
            alu_a    = ctx_q.src;
            alu_b    = mem_rdata_i;
            alu_lane = ctx_q.addr[1:0];
        end
    end

    lrmw_alu u_alu (
        .fn_i    (alu_fn),
        .sz_i    (alu_sz),
        .a_i     (alu_a),
        .b_i     (alu_b),
        .lane_i  (alu_lane),
        .res_o   (alu_res),
        .n_o     (alu_n),
        .z_o     (alu_z),
        .wdata_o (alu_wdata),
        .be_o    (alu_be)
    );

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            ST_IDLE: begin
                if (issue_i) begin
                    if (!dec_legal) begin
                        ctx_d.st = ST_ILL;
                    end else begin
                        ctx_d.fn   = dec_fn;
                        ctx_d.sz   = dec_sz;
                        ctx_d.src  = src_i;
                        ctx_d.addr = dst_i[AW-1:0];
                        ctx_d.v    = flags_i[1];
                        ctx_d.c    = flags_i[0];
                        if (dec_sz == SZ_REG) begin
                            ctx_d.res = alu_res;
                            ctx_d.n   = alu_n;
                            ctx_d.z   = alu_z;
                            ctx_d.st  = ST_FIN;
                        end else begin
                            ctx_d.st  = ST_READ;
                        end
                    end
                end
            end
            ST_READ: begin
                if (mem_ready_i) begin
                    ctx_d.res   = alu_res;
                    ctx_d.wdata = alu_wdata;
                    ctx_d.be    = alu_be;
                    ctx_d.n     = alu_n;
                    ctx_d.z     = alu_z;
                    ctx_d.st    = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ready_i) begin
                    ctx_d.st = ST_FIN;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy_o      = (ctx_q.st != ST_IDLE);
    assign done_o      = (ctx_q.st == ST_FIN);
    assign illegal_o   = (ctx_q.st == ST_ILL);
    assign reg_we_o    = done_o && (ctx_q.sz == SZ_REG);
    assign reg_wdata_o = ctx_q.res;
    assign flags_we_o  = done_o;
    assign flags_o     = {ctx_q.n, ctx_q.z, ctx_q.v, ctx_q.c};
    assign mem_req_o   = (ctx_q.st == ST_READ) || (ctx_q.st == ST_WRITE);
    assign mem_we_o    = (ctx_q.st == ST_WRITE);
    assign mem_addr_o  = {ctx_q.addr[AW-1:2], 2'b00};
    assign mem_be_o    = mem_we_o ? ctx_q.be : '1;
    assign mem_wdata_o = ctx_q.wdata;
endmodule

// File: rtl/lrmw_checker.sv
module lrmw_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_i,
    input logic [3:0]    flags_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          illegal_o,
    input logic          reg_we_o,
    input logic          flags_we_o,
    input logic [3:0]    flags_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [3:0]    mem_be_o,
    input logic [31:0]   mem_wdata_o,
    input logic          mem_ready_i
);
    a_r6_hold_during_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_we_o) &&
        $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_be_o));

    a_r3_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_we_o && mem_ready_i |=> mem_req_o && mem_we_o && $stable(mem_addr_o));

    a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o && mem_ready_i |=> done_o && !mem_req_o);

    a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !done_o && !reg_we_o && !flags_we_o && !mem_req_o);

    a_r2_reg_we_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> done_o && !mem_req_o);

    a_r5_flags_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> flags_we_o);

    a_r5_vc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && $past(issue_i && !busy_o) |-> flags_o[1:0] == $past(flags_i[1:0]));

    a_r8_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o || illegal_o |=> !busy_o && !done_o && !illegal_o);
endmodule

bind logic_rmw_unit lrmw_checker #(.AW(AW)) u_lrmw_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue_i),
    .flags_i     (flags_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o),
    .reg_we_o    (reg_we_o),
    .flags_we_o  (flags_we_o),
    .flags_o     (flags_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i)
);

// File: tb/logic_rmw_unit_bench.sv
module logic_rmw_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [31:0] src_i = '0;
    logic [31:0] dst_i = '0;
    logic [3:0]  flags_i = '0;
    logic        busy_o, done_o, illegal_o, reg_we_o, flags_we_o;
    logic [31:0] reg_wdata_o;
    logic [3:0]  flags_o;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o;
    logic [3:0]  mem_be_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] mem_rdata_i;
    logic        mem_ready_i;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;
    int waits_cfg = 0;
    int wcnt;
    logic [31:0] mem [16];

    always #2.5 clk = ~clk;

    logic_rmw_unit #(.AW(32)) u_logic_rmw_unit (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .opcode_i(opcode_i),
        .src_i(src_i), .dst_i(dst_i), .flags_i(flags_i), .busy_o(busy_o),
        .done_o(done_o), .illegal_o(illegal_o), .reg_we_o(reg_we_o),
        .reg_wdata_o(reg_wdata_o), .flags_we_o(flags_we_o), .flags_o(flags_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i)
    );

    // Memory model: little-endian lanes, programmable wait states.
    assign mem_rdata_i = mem[mem_addr_o[5:2]];
    assign mem_ready_i = mem_req_o && (wcnt == waits_cfg);

    always @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= 32'(32'h9E37_79B9 * (i + 1));
        end else begin
            if (mem_req_o && !mem_ready_i) wcnt <= wcnt + 1;
            else wcnt <= 0;
            if (mem_req_o && mem_we_o && mem_ready_i)
                for (int k = 0; k < 4; k++)
                    if (mem_be_o[k]) mem[mem_addr_o[5:2]][8*k +: 8] <= mem_wdata_o[8*k +: 8];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [31:0] src,
                          input logic [31:0] dst, input logic [3:0] fl, input int waits);
        bit legal;
        int sz;
        int fn;
        int sh;
        int cnt;
        int lat;
        logic [31:0] mask, old, a, b, r, neww, rd_addr, wr_addr, got_reg;
        bit en, ez, seen_rd, seen_wr, got_done, got_ill, got_rwe, got_fwe;
        logic [3:0] got_fl;
        legal = 1'b1;
        sz = 0;
        case (op[2:0])
            3'd2: sz = 0;
            3'd4: sz = 1;
            3'd5: sz = 2;
            3'd6: sz = 3;
            default: legal = 1'b0;
        endcase
        if (op[7:4] == 4'h8) legal = legal && !op[3];
        else if (op[7:4] != 4'h9) legal = 1'b0;
        fn = (op[7:4] == 4'h8) ? 0 : (op[3] ? 2 : 1);
        mask = (sz == 3) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
        sh = (sz == 3) ? 8 * int'(dst[1:0]) : (sz == 2) ? 16 * int'(dst[1]) : 0;
        old = mem[dst[5:2]];
        b = (sz == 0) ? dst : ((old >> sh) & mask);
        a = src & mask;
        r = (fn == 0) ? (a & b) : (fn == 1) ? (a | b) : (a ^ b);
        r = r & mask;
        neww = (old & ~(mask << sh)) | (r << sh);
        en = (sz == 3) ? r[7] : (sz == 2) ? r[15] : r[31];
        ez = (r == 32'h0);
        lat = (sz == 0) ? 1 : 3 + 2 * waits;
        waits_cfg = waits;
        seen_rd = 0; seen_wr = 0; got_done = 0; got_ill = 0; got_rwe = 0; got_fwe = 0;
        rd_addr = '0; wr_addr = '0; got_reg = '0; got_fl = '0;

        @(negedge clk);
        issue_i = 1'b1; opcode_i = op; src_i = src; dst_i = dst; flags_i = fl;
        cnt = 0;
        while (cnt < 60) begin
            @(negedge clk);
            cnt++;
            // R8: poke a new request while busy; it must be ignored.
            issue_i = legal && (sz != 0) && (cnt == 1);
            opcode_i = 8'h82; src_i = ~src; dst_i = ~dst; flags_i = ~fl;
            if (mem_req_o && mem_ready_i) begin
                if (mem_we_o) begin seen_wr = 1; wr_addr = mem_addr_o; end
                else begin seen_rd = 1; rd_addr = mem_addr_o; end
            end
            if (done_o || illegal_o) begin
                got_done = done_o; got_ill = illegal_o; got_rwe = reg_we_o;
                got_fwe = flags_we_o; got_fl = flags_o; got_reg = reg_wdata_o;
                break;
            end
        end
        issue_i = 1'b0;

        if (!legal) begin
            check(got_ill && !got_done, "R7", "illegal pulse", {24'd0, op}, 32'd1);
            check(cnt == 1, "R7", "illegal latency", 32'(cnt), 32'd1);
            check(!seen_rd && !seen_wr && !got_rwe && !got_fwe, "R7", "no side effect",
                  {28'd0, seen_rd, seen_wr, got_rwe, got_fwe}, 32'd0);
            check(mem[dst[5:2]] == old, "R7", "memory unchanged", mem[dst[5:2]], old);
        end else begin
            check(got_done && !got_ill, "R1", "done for legal opcode", {24'd0, op}, 32'd1);
            check(cnt == lat, (sz == 0) ? "R2" : "R6", "latency", 32'(cnt), 32'(lat));
            check(got_fwe && got_fl == {en, ez, fl[1:0]}, "R5", "flags",
                  {27'd0, got_fwe, got_fl}, {27'd1, en, ez, fl[1:0]});
            if (sz == 0) begin
                check(got_rwe && got_reg == r, "R1 R2", "register result", got_reg, r);
                check(!seen_rd && !seen_wr, "R2", "no memory access",
                      {30'd0, seen_rd, seen_wr}, 32'd0);
            end else begin
                check(!got_rwe, "R3", "no register write", {31'd0, got_rwe}, 32'd0);
                check(seen_rd && seen_wr && rd_addr == {dst[31:2], 2'b00} && wr_addr == rd_addr,
                      "R3", "read then write same address", wr_addr, {dst[31:2], 2'b00});
                check(mem[dst[5:2]] == neww, "R1 R4", "memory word", mem[dst[5:2]], neww);
            end
        end
        @(negedge clk);
        check(!done_o && !illegal_o && !busy_o, "R8", "idle after completion",
              {29'd0, done_o, illegal_o, busy_o}, 32'd0);
    endtask

    logic [7:0] ops [12] = '{8'h82, 8'h84, 8'h85, 8'h86, 8'h92, 8'h94,
                             8'h95, 8'h96, 8'h9A, 8'h9C, 8'h9D, 8'h9E};
    logic [31:0] pats [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_8080,
                              32'h1234_5678, 32'hA5A5_A5A5, 32'h0000_FFFF};

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !illegal_o && !reg_we_o && !flags_we_o && !mem_req_o,
              "R9", "reset outputs",
              {26'd0, busy_o, done_o, illegal_o, reg_we_o, flags_we_o, mem_req_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !mem_req_o, "R9", "idle after reset", {30'd0, busy_o, mem_req_o}, 32'd0);

        // Every legal opcode, lane and pattern, with 0..2 wait states.
        for (int o = 0; o < 12; o++)
            for (int p = 0; p < 6; p++)
                for (int ln = 0; ln < 4; ln++)
                    run_op(ops[o], pats[p],
                           ops[o][2:0] == 3'd2 ? pats[(p + ln + 1) % 6]
                                               : {26'd0, 4'(p * 3 + ln), 2'(ln)},
                           4'(p * 5 + ln), (p + ln) % 3);

        // Every opcode value, legal or not.
        for (int op = 0; op < 256; op++)
            run_op(8'(op), 32'hC3C3_0F0F, {26'd0, 4'(op), 2'(op >> 4)}, 4'(op), op % 2);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule